// File: doc/BRIEF.md
# EDO DRAM Device Cycle Decoder Model

A synthesizable, reduced-size behavioural model of an extended-data-out DRAM device, used as the far end when a memory controller is verified. The model samples the active-low row strobe, column strobe, write strobe and output enable, plus the multiplexed address and write data, on a fast clock. From the order in which the strobe edges arrive it decides what kind of cycle the controller has issued. The kinds are: read, early write, output-enable-controlled write, read-modify-write, page read or write, row-only refresh, column-before-row refresh and hidden refresh.

Data lives in a small array addressed by a latched row and column. Read data is held on the output after the column strobe rises. The output then turns off only when both strobes are high, when output enable is high, or when the write strobe falls. An internal counter supplies the row for column-before-row refreshes. Two status outputs report the last decoded cycle kind and the row most recently refreshed, so a bench can check the controller's command sequences against them.

Top module: `edo_dev_model`

## Requirements
- R1: After reset, `drv_en` is 0, `cyc_kind` is 0 (idle), `ref_row` is 0, the refresh counter is 0 and every cell reads as zero.
- R2: A row strobe fall with the column strobe high latches `addr` as the row. A later column strobe fall with the write strobe high latches `addr` as the column and loads the stored word. On the next sampled clock, `rdata` shows that word and `drv_en` is 1 while output enable is low. `cyc_kind` becomes 1 (read) for the first column of a row, 5 (page read) for later ones.
- R3: If the write strobe is low when the column strobe falls, `wdata` at that clock is stored and `drv_en` stays 0. `cyc_kind` becomes 2 (early write), or 6 (page write) for a later column of the same row.
- R4: A write strobe fall while the column strobe is low stores `wdata` at that clock into the latched column. `cyc_kind` becomes 4 (read-modify-write) if the read word was driven during this column phase, and 3 (output-enable write) otherwise. For a later column of the same row it becomes 6.
- R5: Once the column strobe rises with the row strobe low, the read word stays on the output. The output turns off only when both strobes are high, whichever of them rises last.
- R6: While the row strobe stays low, each column strobe fall latches a new column, so reads and writes mix freely in one row.
- R7: A row strobe cycle with no column strobe fall sets `cyc_kind` to 7 at the row strobe rise. `ref_row` takes the row address when the row strobe falls, and `drv_en` stays 0.
- R8: If the column strobe is already low when the row strobe falls, the address is ignored. `ref_row` takes the counter value, the counter advances by one (wrapping), and `cyc_kind` becomes 8.
- R9: If read data is still held when such a refresh starts, the data stays on the output and `cyc_kind` becomes 9 (hidden refresh).
- R10: Output enable sampled high, or a write strobe fall, turns `drv_en` off at that clock; `rdata` is 0 whenever `drv_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, 0 when not driven |
| drv_en | output | 1 | Output driven (low means high impedance) |
| cyc_kind | output | 4 | Last decoded cycle kind (codes in R2 to R9) |
| ref_row | output | ADDR_W | Row refreshed most recently |

## Verification
On every cycle, the assertions check the output turn-off rules: output enable high, a write strobe fall, both strobes high, and the quiet output of an early write. They also check that a column-before-row refresh reports the counter and advances it, and that a hidden refresh keeps the data driven. Only the bench's scenarios can show the stored contents through read-back. The same holds for the kind codes that separate read-modify-write from output-enable writes and first-column from page accesses, and for the counter wrapping after a full sweep of rows. The bench's reference model follows every clock, so an ordering error shows up at the cycle where it occurs.

// File: rtl/edo_dev_pkg.sv
package edo_dev_pkg;
    typedef enum logic [3:0] {
        K_IDLE    = 4'd0,
        K_READ    = 4'd1,
        K_EWRITE  = 4'd2,
        K_OEWRITE = 4'd3,
        K_RMW     = 4'd4,
        K_PG_RD   = 4'd5,
        K_PG_WR   = 4'd6,
        K_ROWREF  = 4'd7,
        K_CBR     = 4'd8,
        K_HIDDEN  = 4'd9
    } cyc_kind_e;

    localparam int S_RAS = 0;
    localparam int S_CAS = 1;
    localparam int S_WE  = 2;
    localparam int S_OE  = 3;
    localparam int N_STROBES = 4;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev,
    output logic [N-1:0] fell,
    output logic [N-1:0] rose
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign fell[i] = prev_q[i] & ~lvl[i];
        assign rose[i] = ~prev_q[i] & lvl[i];
    end

    assign prev = prev_q;
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (wr_en) begin
            cell_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/edo_dev_model.sv
module edo_dev_model
    import edo_dev_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              drv_en,
    output logic [3:0]        cyc_kind,
    output logic [ADDR_W-1:0] ref_row
);
    localparam int CELL_AW = 2 * ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] rcnt;
        logic [ADDR_W-1:0] rrow;
        logic              act;
        logic              seen;
        logic              page;
        logic              cph;
        logic              dok;
        logic              shown;
        logic              drv;
        logic [DW-1:0]     dq;
        cyc_kind_e         kind;
    } st_t;

    st_t s_d, s_q;

    logic [N_STROBES-1:0] lvl, prev, fell, rose;
    logic                 wr_en;
    logic [CELL_AW-1:0]   wr_addr, rd_addr;
    logic [DW-1:0]        rd_data;

    assign lvl = {oe_n, we_n, cas_n, ras_n};

    edo_strobe_edges #(.N(N_STROBES)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .prev (prev),
        .fell (fell),
        .rose (rose)
    );

    logic ras_fell, ras_rose, cas_fell, cas_rose, we_fell, cas_was_low;
    assign ras_fell    = fell[S_RAS];
    assign ras_rose    = rose[S_RAS];
    assign cas_fell    = fell[S_CAS];
    assign cas_rose    = rose[S_CAS];
    assign we_fell     = fell[S_WE];
    assign cas_was_low = ~prev[S_CAS];

    logic unused_edges;
    assign unused_edges = ^{rose[S_OE], rose[S_WE], fell[S_OE], prev[S_OE], prev[S_WE], prev[S_RAS]};

    assign rd_addr = {s_q.row, addr};

    edo_cell_array #(.AW(CELL_AW), .DW(DW)) u_cells (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wdata),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_addr = {s_q.row, s_q.col};

        // Row strobe edges: refresh by counter, or open a row
        if (ras_fell) begin
            if (cas_was_low) begin
                s_d.rrow = s_q.rcnt;
                s_d.rcnt = s_q.rcnt + 1'b1;
                s_d.kind = s_q.dok ? K_HIDDEN : K_CBR;
                s_d.act  = 1'b0;
                s_d.cph  = 1'b0;
            end else begin
                s_d.row  = addr;
                s_d.rrow = addr;
                s_d.act  = 1'b1;
                s_d.seen = 1'b0;
            end
        end
        if (ras_rose) begin
            if (s_q.act && !s_q.seen) s_d.kind = K_ROWREF;
            s_d.act = 1'b0;
        end

        // Column strobe fall inside an open row
        if (cas_fell && s_q.act && !ras_n) begin
            s_d.col   = addr;
            s_d.cph   = 1'b1;
            s_d.seen  = 1'b1;
            s_d.page  = s_q.seen;
            s_d.shown = 1'b0;
            if (!we_n) begin
                wr_en    = 1'b1;
                wr_addr  = {s_q.row, addr};
                s_d.dok  = 1'b0;
                s_d.kind = s_q.seen ? K_PG_WR : K_EWRITE;
            end else begin
                s_d.dq   = rd_data;
                s_d.dok  = 1'b1;
                s_d.kind = s_q.seen ? K_PG_RD : K_READ;
            end
        end else if (we_fell && s_q.act && s_q.cph && !cas_n) begin
            wr_en    = 1'b1;
            s_d.dok  = 1'b0;
            if (s_q.page)       s_d.kind = K_PG_WR;
            else if (s_q.shown) s_d.kind = K_RMW;
            else                s_d.kind = K_OEWRITE;
        end

        if (cas_rose) s_d.cph = 1'b0;
        if (we_fell) s_d.dok = 1'b0;
        if (ras_n && cas_n) s_d.dok = 1'b0;

        s_d.drv   = s_d.dok & ~oe_n;
        s_d.shown = s_d.shown | s_d.drv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= K_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign drv_en   = s_q.drv;
    assign rdata    = s_q.drv ? s_q.dq : '0;
    assign cyc_kind = s_q.kind;
    assign ref_row  = s_q.rrow;

    // R10
    we_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_fell |=> !drv_en);

    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !drv_en);

    // R5
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_n) |=> !drv_en);

    // R3
    ewrite_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fell && s_q.act && !ras_n && !we_n) |=> !drv_en);

    // R8
    cbr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fell && cas_was_low) |=>
            (ref_row == $past(s_q.rcnt)) && (s_q.rcnt == ADDR_W'($past(s_q.rcnt) + 1'b1)));

    // R9
    hidden_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fell && cas_was_low && s_q.drv && !oe_n && !we_fell) |=> (drv_en && cyc_kind == K_HIDDEN));
endmodule

// File: tb/edo_dev_model_bench.sv
module edo_dev_model_bench;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int ROWS = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic drv_en;
    logic [3:0] cyc_kind;
    logic [AW-1:0] ref_row;

    always #4 clk = ~clk;

    edo_dev_model #(.ADDR_W(AW), .DW(DW)) u_edo_dev_model (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .drv_en(drv_en),
        .cyc_kind(cyc_kind), .ref_row(ref_row)
    );

    int n_run = 0, n_fail = 0;
    string tag = "R1";
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference model, updated on each rising edge
    int  m_mem [ROWS*ROWS];
    int  m_row, m_col, m_cnt, m_rrow, m_kind, m_dq;
    bit  m_open, m_any, m_pg, m_inph, m_hold, m_was, m_on;
    bit  p_ras = 1, p_cas = 1, p_we = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_row = 0; m_col = 0; m_cnt = 0; m_rrow = 0; m_kind = 0; m_dq = 0;
            m_open = 0; m_any = 0; m_pg = 0; m_inph = 0; m_hold = 0; m_was = 0; m_on = 0;
            p_ras = 1; p_cas = 1; p_we = 1;
        end else begin
            bit r_dn, r_up, c_dn, c_up, w_dn, o_open, o_any, o_pg, o_inph, o_hold, o_was;
            int o_row, o_col;
            r_dn = p_ras && !ras_n; r_up = !p_ras && ras_n;
            c_dn = p_cas && !cas_n; c_up = !p_cas && cas_n;
            w_dn = p_we && !we_n;
            o_open = m_open; o_any = m_any; o_pg = m_pg; o_inph = m_inph;
            o_hold = m_hold; o_was = m_was; o_row = m_row; o_col = m_col;
            if (r_dn && !p_cas) begin
                m_rrow = m_cnt; m_cnt = (m_cnt + 1) % ROWS;
                m_kind = o_hold ? 9 : 8; m_open = 0; m_inph = 0;
            end else if (r_dn) begin
                m_row = addr; m_rrow = addr; m_open = 1; m_any = 0;
            end
            if (r_up) begin
                if (o_open && !o_any) m_kind = 7;
                m_open = 0;
            end
            if (c_dn && o_open && !ras_n) begin
                m_col = addr; m_inph = 1; m_any = 1; m_pg = o_any; m_was = 0;
                if (!we_n) begin
                    m_mem[o_row*ROWS + addr] = wdata; m_hold = 0; m_kind = o_any ? 6 : 2;
                end else begin
                    m_dq = m_mem[o_row*ROWS + addr]; m_hold = 1; m_kind = o_any ? 5 : 1;
                end
            end else if (w_dn && o_open && o_inph && !cas_n) begin
                m_mem[o_row*ROWS + o_col] = wdata; m_hold = 0;
                m_kind = o_pg ? 6 : (o_was ? 4 : 3);
            end
            if (c_up) m_inph = 0;
            if (w_dn) m_hold = 0;
            if (ras_n && cas_n) m_hold = 0;
            m_on = m_hold && !oe_n;
            if (m_on) m_was = 1;
            p_ras = ras_n; p_cas = cas_n; p_we = we_n;
        end
    end

    // Compare design and model on every clock
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk({tag, " drv"}, drv_en, m_on);
            chk({tag, " data"}, rdata, m_on ? m_dq : 0);
            chk({tag, " kind"}, cyc_kind, m_kind);
            chk({tag, " ref"}, ref_row, m_rrow);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ewrite(input int row, input int col, input int d);
        addr = AW'(row); ras_n = 0; step();
        addr = AW'(col); wdata = DW'(d); we_n = 0; cas_n = 0; step();
        cas_n = 1; we_n = 1; step();
        ras_n = 1; step();
    endtask

    task automatic rd_open(input int row, input int col);
        oe_n = 0; addr = AW'(row); ras_n = 0; step();
        addr = AW'(col); cas_n = 0; step();
    endtask

    task automatic cbr();
        addr = AW'(7); cas_n = 0; step();
        ras_n = 0; step();
        ras_n = 1; step();
        cas_n = 1; step();
    endtask

    int cbr_n = 0;

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        // R1
        chk("R1 drv", drv_en, 0); chk("R1 kind", cyc_kind, 0); chk("R1 ref", ref_row, 0);

        tag = "R3";
        addr = 2; ras_n = 0; step();
        addr = 5; wdata = 8'hA5; we_n = 0; cas_n = 0; oe_n = 0; step();
        chk("R3 kind", cyc_kind, 2); chk("R3 quiet", drv_en, 0);
        cas_n = 1; we_n = 1; step(); ras_n = 1; oe_n = 1; step();

        tag = "R2";
        rd_open(2, 5);
        chk("R2 drv", drv_en, 1); chk("R2 data", rdata, 8'hA5); chk("R2 kind", cyc_kind, 1);
        tag = "R5";
        cas_n = 1; step();
        chk("R5 hold", rdata, 8'hA5);
        ras_n = 1; step();
        chk("R5 off after row", drv_en, 0);
        rd_open(2, 5);
        ras_n = 1; step();
        chk("R5 hold col low", drv_en, 1);
        cas_n = 1; step();
        chk("R5 off after col", drv_en, 0);
        oe_n = 1; step();

        tag = "R4";
        addr = 3; ras_n = 0; step();
        addr = 1; cas_n = 0; step();
        wdata = 8'h3C; we_n = 0; step();
        chk("R4 oewrite", cyc_kind, 3);
        cas_n = 1; we_n = 1; step(); ras_n = 1; step();
        rd_open(3, 1);
        chk("R4 readback", rdata, 8'h3C);
        tag = "R10";
        oe_n = 1; step();
        chk("R10 oe off", drv_en, 0);
        tag = "R4";
        wdata = 8'hC3; we_n = 0; step();
        chk("R4 rmw", cyc_kind, 4);
        cas_n = 1; we_n = 1; step(); ras_n = 1; step();
        rd_open(3, 1);
        chk("R4 rmw data", rdata, 8'hC3);
        tag = "R10";
        wdata = 8'h77; we_n = 0; step();
        chk("R10 we off", drv_en, 0);
        cas_n = 1; we_n = 1; step(); ras_n = 1; oe_n = 1; step();

        tag = "R6";
        addr = 4; ras_n = 0; step();
        addr = 0; wdata = 8'h11; we_n = 0; cas_n = 0; step(); chk("R6 first", cyc_kind, 2);
        cas_n = 1; we_n = 1; step();
        addr = 1; wdata = 8'h22; we_n = 0; cas_n = 0; step(); chk("R6 pgwr", cyc_kind, 6);
        cas_n = 1; we_n = 1; oe_n = 0; step();
        addr = 0; cas_n = 0; step(); chk("R6 pgrd", cyc_kind, 5); chk("R6 d0", rdata, 8'h11);
        cas_n = 1; step();
        addr = 1; cas_n = 0; step(); chk("R6 d1", rdata, 8'h22);
        cas_n = 1; oe_n = 1; step();
        addr = 2; cas_n = 0; step();
        wdata = 8'h33; we_n = 0; step(); chk("R6 late pgwr", cyc_kind, 6);
        cas_n = 1; we_n = 1; step(); ras_n = 1; step();
        rd_open(4, 2); chk("R6 d2", rdata, 8'h33);
        cas_n = 1; ras_n = 1; oe_n = 1; step();

        tag = "R7";
        addr = 6; ras_n = 0; step(); chk("R7 ref", ref_row, 6);
        ras_n = 1; step(); chk("R7 kind", cyc_kind, 7); chk("R7 quiet", drv_en, 0);

        tag = "R8";
        cbr(); chk("R8 ref", ref_row, 0); chk("R8 kind", cyc_kind, 8); cbr_n++;
        for (int i = 0; i < ROWS; i++) begin
            cbr(); chk("R8 sweep", ref_row, cbr_n % ROWS); cbr_n++;
        end

        tag = "R9";
        rd_open(2, 5);
        ras_n = 1; step();
        ras_n = 0; step();
        chk("R9 kind", cyc_kind, 9); chk("R9 drv", drv_en, 1); chk("R9 data", rdata, 8'hA5);
        chk("R9 ref", ref_row, cbr_n % ROWS); cbr_n++;
        ras_n = 1; step();
        cas_n = 1; step(); chk("R9 off", drv_en, 0);
        oe_n = 1; repeat (3) step();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule